// File: doc/BRIEF.md
# Three-wire serial byte receiver

This block is the front end of a display controller's write-only serial port. The external side has four lines: an active-low chip enable, a serial clock, a serial data line and a data/command select. The block samples all four lines in a faster system clock domain. It finds the rising edges of the serial clock, shifts in eight bits with the most significant bit first, and hands each finished byte to the command decoder. The byte comes with a flag that marks it as a command or as display data, and with a strobe that is high for one system cycle.

A transfer starts when chip enable goes low. While chip enable stays low, bytes follow one another with no gap. Chip enable going high or the asynchronous reset drops a byte that is only partly received, and nothing is delivered for it. After either one, reception starts again at bit 7 of a fresh byte.

Top module: `ser_byte_rx`

## Requirements
- R1: While `rst_ni` is low and after it is released, `byte_o` is 0x00, `is_data_o` is 0 and `valid_o` is 0 until a full byte has been received.
- R2: The value on `sdin_i` at each rising edge of `sclk_i` is shifted in MSB first: the first sampled bit lands in `byte_o[7]` and the eighth in `byte_o[0]`.
- R3: `is_data_o` takes the level of `dc_i` at the eighth rising serial clock edge of the byte (0 = command, 1 = display data). The level of `dc_i` at the first seven edges has no effect.
- R4: Each completed byte raises `valid_o` for exactly one system cycle. `byte_o` and `is_data_o` change only on the cycle in which `valid_o` is raised.
- R5: While `sce_ni` is high, rising edges of `sclk_i` are ignored: no byte is delivered and the bit counter stays at bit 7.
- R6: If `sce_ni` goes high in the middle of a byte, the partial byte is dropped. The next byte after `sce_ni` falls again starts at bit 7.
- R7: While `sce_ni` stays low, the rising serial edge after the eighth bit is taken as bit 7 of the next byte, so bytes can stream back to back.
- R8: A low pulse on `rst_ni` in the middle of a byte discards the partial byte and clears the outputs. If `sce_ni` is low after release, the next rising serial edge is bit 7.
- R9: With inputs that change away from system clock edges, `valid_o` is high after exactly the third rising `clk_i` edge that follows the eighth rising edge of `sclk_i`, and low after the second. The system clock must run at least four times faster than the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sce_ni | input | 1 | Serial chip enable, active low |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdin_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| dc_i | input | 1 | Data/command select, 1 = display data |
| byte_o | output | 8 | Last completed byte |
| is_data_o | output | 1 | Data/command flag of `byte_o` |
| valid_o | output | 1 | One-cycle strobe for a new byte |

## Verification
Fixed bytes with mixed bit patterns (0xA5, 0x3C, 0x01, 0x80, 0xFF) detect bit order, stuck bits and off-by-one shifts in the assembly. For the flag test, `dc_i` is held at the opposite level for the first seven bits and set to the wanted level only on the eighth edge, in both directions, so a design that latches the flag too early is caught. Bursts of serial clock while chip enable is high, and bytes cut short by chip enable or by reset, are each followed by a known byte. A counter that was not held or cleared would then deliver a byte that is rotated or arrives early. Back-to-back streaming and an exact cycle count from the eighth serial edge to the strobe check the counter wrap and the pipeline depth.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SYNC_LEN = 2;

  // bit positions inside the synchroniser vector
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_SDIN = 1;
  localparam int unsigned IDX_DC   = 2;
  localparam int unsigned IDX_CE_N = 3;
  localparam int unsigned LINES    = 4;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_edge.sv
module ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R9: a legal serial clock gives isolated single-cycle rise pulses
  a_r9_rise_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              ce_n_i,
  input  logic              sdin_i,
  input  logic              dc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_data_o,
  output logic              valid_o
);
  localparam int unsigned    CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      shreg_q   <= '0;
      byte_o    <= '0;
      is_data_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (ce_n_i) begin
        cnt_q <= '0;  // idle: next edge is bit 7
      end else if (rise_i) begin
        shreg_q <= {shreg_q[BYTE_W-3:0], sdin_i};
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          byte_o    <= {shreg_q, sdin_i};
          is_data_o <= dc_i;
          valid_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4: outputs move only with the strobe
  a_r4_byte_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(byte_o) |-> valid_o);
  // R3: flag moves only with the strobe
  a_r3_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(is_data_o) |-> valid_o);
  // R4: strobe is caused by a serial edge
  a_r4_valid_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));
endmodule

// File: rtl/ser_byte_rx.sv
module ser_byte_rx
  import ser_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sce_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              dc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_data_o,
  output logic              valid_o
);
  localparam logic [LINES-1:0] SYNC_RST = LINES'(1) << IDX_CE_N;

  logic [LINES-1:0] raw, synced;
  logic             sclk_rise;

  always_comb begin
    raw           = '0;
    raw[IDX_SCLK] = sclk_i;
    raw[IDX_SDIN] = sdin_i;
    raw[IDX_DC]   = dc_i;
    raw[IDX_CE_N] = sce_ni;
  end

  ser_sync #(
    .W      (LINES),
    .STAGES (SYNC_LEN),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  ser_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (synced[IDX_SCLK]),
    .rise_o(sclk_rise)
  );

  ser_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (sclk_rise),
    .ce_n_i   (synced[IDX_CE_N]),
    .sdin_i   (synced[IDX_SDIN]),
    .dc_i     (synced[IDX_DC]),
    .byte_o   (byte_o),
    .is_data_o(is_data_o),
    .valid_o  (valid_o)
  );

  // R5: no delivery while the port is deselected
  a_r5_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced[IDX_CE_N] |=> !valid_o);
  // R4: strobe is a single cycle
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/ser_byte_rx_bench.sv
module ser_byte_rx_bench;
  localparam int HALF = 5;  // system cycles per serial half period

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sce_ni = 1'b1;
  logic       sclk = 1'b0;
  logic       sdin = 1'b0;
  logic       dc = 1'b0;
  logic [7:0] byte_o;
  logic       is_data_o;
  logic       valid_o;

  int n_chk = 0, n_bad = 0;
  int got = 0, run = 0, max_run = 0;
  logic [7:0] last_byte = '0;
  logic       last_dc = 1'b0;
  bit         done = 0;

  always #5 clk = ~clk;

  ser_byte_rx u_ser_byte_rx (
    .clk_i(clk), .rst_ni(rst_ni), .sce_ni(sce_ni), .sclk_i(sclk),
    .sdin_i(sdin), .dc_i(dc), .byte_o(byte_o), .is_data_o(is_data_o),
    .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      got++; run++;
      last_byte = byte_o;
      last_dc = is_data_o;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic select();
    @(negedge clk); sce_ni = 1'b0; wait_cyc(HALF);
  endtask

  task automatic deselect();
    @(negedge clk); sce_ni = 1'b1; wait_cyc(HALF);
  endtask

  // nbits bits of b, MSB first; dc_early on bits 1..7, dc_last on bit 8
  task automatic send_bits(input logic [7:0] b, input int nbits,
                           input logic dc_early, input logic dc_last);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sdin = b[7-i];
      dc = (i == 7) ? dc_last : dc_early;
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
    end
    wait_cyc(HALF);
  endtask

  task automatic expect_byte(input int base, input logic [7:0] b,
                             input logic d, input string tag);
    chk(got == base + 1, {tag, " count"}, got, base + 1);
    chk(last_byte == b, {tag, " byte"}, last_byte, b);
    chk(last_dc == d, {tag, " flag"}, last_dc, d);
  endtask

  task automatic t_reset();
    chk(byte_o == 8'h00 && !is_data_o && !valid_o, "R1 reset outputs",
        {byte_o, is_data_o, valid_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    wait_cyc(4);
    chk(byte_o == 8'h00 && !is_data_o && !valid_o && got == 0,
        "R1 after release", {byte_o, is_data_o, valid_o}, 0);
  endtask

  task automatic t_basic();
    int b = got;
    select();
    send_bits(8'hA5, 8, 1'b0, 1'b0);
    expect_byte(b, 8'hA5, 1'b0, "R2 cmd A5");
    b = got;
    send_bits(8'h3C, 8, 1'b1, 1'b1);
    expect_byte(b, 8'h3C, 1'b1, "R2 data 3C");
    deselect();
  endtask

  task automatic t_dc_late();
    int b = got;
    select();
    send_bits(8'h69, 8, 1'b0, 1'b1);
    expect_byte(b, 8'h69, 1'b1, "R3 late high");
    b = got;
    send_bits(8'h96, 8, 1'b1, 1'b0);
    expect_byte(b, 8'h96, 1'b0, "R3 late low");
    deselect();
  endtask

  task automatic t_stream();
    int b = got;
    select();
    send_bits(8'h01, 8, 1'b1, 1'b1);
    expect_byte(b, 8'h01, 1'b1, "R7 stream 1");
    send_bits(8'h80, 8, 1'b0, 1'b0);
    expect_byte(b + 1, 8'h80, 1'b0, "R7 stream 2");
    send_bits(8'hFF, 8, 1'b1, 1'b1);
    expect_byte(b + 2, 8'hFF, 1'b1, "R7 stream 3");
    deselect();
  endtask

  task automatic t_idle();
    int b = got;
    @(negedge clk); sce_ni = 1'b1;
    send_bits(8'hF0, 8, 1'b1, 1'b1);
    send_bits(8'h0F, 8, 1'b0, 1'b0);
    chk(got == b, "R5 edges ignored", got, b);
    select();
    send_bits(8'h5A, 8, 1'b0, 1'b1);
    expect_byte(b, 8'h5A, 1'b1, "R5 counter held");
    deselect();
  endtask

  task automatic t_abort_ce();
    int b = got;
    select();
    send_bits(8'hE0, 3, 1'b1, 1'b1);
    deselect();
    chk(got == b, "R6 partial dropped", got, b);
    select();
    send_bits(8'hC3, 8, 1'b0, 1'b0);
    expect_byte(b, 8'hC3, 1'b0, "R6 restart bit7");
    deselect();
  endtask

  task automatic t_abort_rst();
    int b = got;
    select();
    send_bits(8'hF8, 5, 1'b1, 1'b1);
    @(negedge clk); rst_ni = 1'b0;
    wait_cyc(2);
    chk(byte_o == 8'h00 && !is_data_o, "R8 outputs cleared", byte_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    wait_cyc(HALF);
    chk(got == b, "R8 partial dropped", got, b);
    send_bits(8'h4B, 8, 1'b1, 1'b1);
    expect_byte(b, 8'h4B, 1'b1, "R8 restart bit7");
    deselect();
  endtask

  task automatic t_latency();
    select();
    send_bits(8'hD2, 7, 1'b0, 1'b0);
    @(negedge clk); sdin = 1'b0; dc = 1'b1;
    wait_cyc(HALF);
    sclk = 1'b1;                    // eighth edge, driven at a negedge
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(valid_o == 1'b0, "R9 not before 3rd edge", valid_o, 0);
    @(posedge clk); @(negedge clk);
    chk(valid_o == 1'b1 && byte_o == 8'hD2, "R9 at 3rd edge",
        {valid_o, byte_o}, {1'b1, 8'hD2});
    @(negedge clk);
    chk(valid_o == 1'b0, "R4 strobe one cycle", valid_o, 0);
    wait_cyc(HALF); sclk = 1'b0;
    deselect();
    chk(max_run == 1, "R4 max strobe width", max_run, 1);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    t_basic();
    t_dc_late();
    t_stream();
    t_idle();
    t_abort_ce();
    t_abort_rst();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule